// File: doc/BRIEF.md
# Eight-Register Multicycle Processor Core

This block is a small processor core that steps through a compact eight-operation instruction set. It has eight 32-bit general registers and one word-addressed memory that holds both the program and its data. Each instruction is a word whose bits 24 to 22 select the operation. The core runs each instruction over two or three clock cycles. It fetches the word, decodes and executes it, and for loads and stores spends one more cycle on the memory access.

Before a run, the surrounding logic (here the testbench) fills memory through a preload stream. Each word is written in a cycle where `load_valid` and `load_ready` are both high. `load_ready` is high only while the core is idle after reset, so the source must hold a word until it is accepted, and words offered after start are never taken. A one-cycle `start` pulse begins execution at address 0. The core runs until it executes a halt. It then raises `halted` and stays stopped until reset. Two combinational debug ports read any register and any memory word, and a counter reports how many instructions have executed.

Top module: `mc8_core`

## Requirements
- R1: After reset, all eight registers, the PC and `instr_count` are zero, `halted` is low and `load_ready` is high.
- R2: While idle, a word is written to `load_addr` in each cycle where `load_valid` and `load_ready` are both high, and `dbg_mem_data` returns it. `load_ready` is low from the start pulse onward.
- R3: Fields: the opcode is bits 24-22, register A is bits 21-19, register B is bits 18-16, the destination of add and nand is bits 2-0, and the offset is bits 15-0. Bits 31-25 are ignored, and bits 15-3 are ignored by add and nand. Opcodes: add 000, nand 001, load 010, store 011, beq 100, jalr 101, halt 110, noop 111.
- R4: add writes A+B to the destination register, and nand writes ~(A&B). Register 0 is an ordinary writable register.
- R5: load writes mem[A+sext(offset)] into register B, and store writes register B into that word. The address wraps modulo the 256-word depth.
- R6: beq sets the PC to pc+1+sext(offset) when A equals B, and to pc+1 otherwise. The offset may be negative.
- R7: jalr writes pc+1 into register B and sets the PC to the old value of register A. This holds when both fields name the same register.
- R8: halt stops the core and raises `halted`, which stays high until reset. noop changes nothing except the PC.
- R9: From the edge that samples `start`, each add, nand, beq, jalr, noop and halt takes 2 cycles, and each load and store takes 3 cycles.
- R10: `instr_count` counts every executed instruction, halt included.
- R11: After start, preload words are not written to memory, and a `start` pulse while halted has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at address 0 (honoured only when idle) |
| halted | output | 1 | High once a halt has executed |
| load_valid | input | 1 | Preload word offered |
| load_ready | output | 1 | Preload word accepted (idle only) |
| load_addr | input | 8 | Preload word address |
| load_data | input | 32 | Preload word value |
| dbg_reg_sel | input | 3 | Debug register index |
| dbg_reg_data | output | 32 | Value of the selected register |
| dbg_mem_addr | input | 8 | Debug memory address |
| dbg_mem_data | output | 32 | Value of the addressed word |
| instr_count | output | 32 | Executed instruction count |

## Verification
The hardest case to reach from the ports is a jalr whose link register and target register are the same. A wrong write order leaves no visible error unless the code at the linked address and the code at the jump target behave differently. The bench therefore places a halt at pc+1 and a distinct path at the real target, so a wrong order changes both the instruction count and the final register values. Address wrap-around and negative branch offsets are reached the same way: the program loads operands from preloaded data words, so a register holds a value that makes the effective address cross the end of memory.

// File: rtl/mc8_pkg.sv
package mc8_pkg;
  localparam int RIDX_W = 3;
  localparam int OFF_W  = 16;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_NAND = 3'd1,
    OP_LW   = 3'd2,
    OP_SW   = 3'd3,
    OP_BEQ  = 3'd4,
    OP_JALR = 3'd5,
    OP_HALT = 3'd6,
    OP_NOOP = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_MEMWB,
    ST_HALT
  } state_e;

  typedef struct packed {
    op_e               op;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [RIDX_W-1:0] rd;
    logic [OFF_W-1:0]  off;
  } instr_t;
endpackage

// File: rtl/mc8_regfile.sv
module mc8_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   ra_idx,
  input  logic [IW-1:0]   rb_idx,
  output logic [XLEN-1:0] ra_data,
  output logic [XLEN-1:0] rb_data,
  input  logic            we,
  input  logic [IW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [IW-1:0]   dbg_idx,
  output logic [XLEN-1:0] dbg_data
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign ra_data  = regs[ra_idx];
  assign rb_data  = regs[rb_idx];
  assign dbg_data = regs[dbg_idx];

  // R4: a write lands in the named register
  p_wb_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(wa)] == $past(wd));
endmodule

// File: rtl/mc8_mem.sv
module mc8_mem #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [XLEN-1:0] rdata,
  input  logic [AW-1:0]   dbg_addr,
  output logic [XLEN-1:0] dbg_data
);
  logic [XLEN-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata    = words[raddr];
  assign dbg_data = words[dbg_addr];

  // R5: a write is visible at its address next cycle
  p_store_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> words[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/mc8_alu.sv
module mc8_alu #(
  parameter int XLEN = 32
) (
  input  mc8_pkg::op_e    op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [15:0]     off,
  output logic [XLEN-1:0] result,
  output logic            eq
);
  import mc8_pkg::*;
  logic [XLEN-1:0] sext;

  assign sext = {{(XLEN-16){off[15]}}, off};
  assign eq   = (a == b);

  always_comb begin
    unique case (op)
      OP_ADD:       result = a + b;
      OP_NAND:      result = ~(a & b);
      OP_LW, OP_SW: result = a + sext;
      default:      result = '0;
    endcase
  end
endmodule

// File: rtl/mc8_core.sv
module mc8_core #(
  parameter int XLEN  = 32,
  parameter int NREG  = 8,
  parameter int DEPTH = 256,
  parameter int CW    = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            halted,
  input  logic            load_valid,
  output logic            load_ready,
  input  logic [AW-1:0]   load_addr,
  input  logic [XLEN-1:0] load_data,
  input  logic [IW-1:0]   dbg_reg_sel,
  output logic [XLEN-1:0] dbg_reg_data,
  input  logic [AW-1:0]   dbg_mem_addr,
  output logic [XLEN-1:0] dbg_mem_data,
  output logic [CW-1:0]   instr_count
);
  import mc8_pkg::*;

  state_e          state;
  logic [AW-1:0]   pc;
  logic [AW-1:0]   pc_inc;
  logic [XLEN-1:0] ir;
  logic [AW-1:0]   maddr;
  instr_t          d;
  logic            unused_bits;

  logic [XLEN-1:0] ra_data, rb_data, alu_res, mem_rdata;
  logic            alu_eq;
  logic            rf_we, mem_we;
  logic [IW-1:0]   rf_wa;
  logic [XLEN-1:0] rf_wd, mem_wdata;
  logic [AW-1:0]   mem_waddr, mem_raddr;
  logic [AW-1:0]   sext_pc;

  // field decode (R3)
  assign d.op  = op_e'(ir[24:22]);
  assign d.ra  = ir[21:19];
  assign d.rb  = ir[18:16];
  assign d.rd  = ir[2:0];
  assign d.off = ir[15:0];
  assign unused_bits = ^ir[31:25];

  assign pc_inc  = pc + AW'(1);
  assign sext_pc = AW'({{(XLEN-16){d.off[15]}}, d.off});

  mc8_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(d.ra[IW-1:0]), .rb_idx(d.rb[IW-1:0]),
    .ra_data(ra_data), .rb_data(rb_data),
    .we(rf_we), .wa(rf_wa), .wd(rf_wd),
    .dbg_idx(dbg_reg_sel), .dbg_data(dbg_reg_data)
  );

  mc8_alu #(.XLEN(XLEN)) u_alu (
    .op(d.op), .a(ra_data), .b(rb_data), .off(d.off),
    .result(alu_res), .eq(alu_eq)
  );

  mc8_mem #(.XLEN(XLEN), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata),
    .dbg_addr(dbg_mem_addr), .dbg_data(dbg_mem_data)
  );

  assign load_ready = (state == ST_IDLE);
  assign halted     = (state == ST_HALT);

  // memory port steering: preload while idle, store in the access cycle
  always_comb begin
    mem_raddr = (state == ST_MEMWB) ? maddr : pc;
    mem_we    = 1'b0;
    mem_waddr = load_addr;
    mem_wdata = load_data;
    if (state == ST_IDLE) begin
      mem_we = load_valid;
    end else if (state == ST_MEMWB && d.op == OP_SW) begin
      mem_we    = 1'b1;
      mem_waddr = maddr;
      mem_wdata = rb_data;
    end
  end

  // register write steering
  always_comb begin
    rf_we = 1'b0;
    rf_wa = d.rb[IW-1:0];
    rf_wd = alu_res;
    if (state == ST_EXEC) begin
      unique case (d.op)
        OP_ADD, OP_NAND: begin
          rf_we = 1'b1;
          rf_wa = d.rd[IW-1:0];
        end
        OP_JALR: begin
          rf_we = 1'b1;
          rf_wd = {{(XLEN-AW){1'b0}}, pc_inc};
        end
        default: ;
      endcase
    end else if (state == ST_MEMWB && d.op == OP_LW) begin
      rf_we = 1'b1;
      rf_wd = mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      pc          <= '0;
      ir          <= '0;
      maddr       <= '0;
      instr_count <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  if (start) state <= ST_FETCH;
        ST_FETCH: begin
          ir    <= mem_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          unique case (d.op)
            OP_LW, OP_SW: begin
              maddr <= alu_res[AW-1:0];
              state <= ST_MEMWB;
            end
            OP_BEQ: begin
              pc          <= alu_eq ? pc_inc + sext_pc : pc_inc;
              instr_count <= instr_count + CW'(1);
              state       <= ST_FETCH;
            end
            OP_JALR: begin
              pc          <= ra_data[AW-1:0];
              instr_count <= instr_count + CW'(1);
              state       <= ST_FETCH;
            end
            OP_HALT: begin
              pc          <= pc_inc;
              instr_count <= instr_count + CW'(1);
              state       <= ST_HALT;
            end
            default: begin
              pc          <= pc_inc;
              instr_count <= instr_count + CW'(1);
              state       <= ST_FETCH;
            end
          endcase
        end
        ST_MEMWB: begin
          pc          <= pc_inc;
          instr_count <= instr_count + CW'(1);
          state       <= ST_FETCH;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  // R8: halted never drops before reset
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R10: count advances by at most one per cycle
  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_count == $past(instr_count)) || (instr_count == $past(instr_count) + CW'(1)));

  // R2: preload is accepted only before anything has executed
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ready |-> (!halted && instr_count == '0));

  // R9: memory operations take the extra access cycle
  p_mem_extra_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && (d.op == OP_LW || d.op == OP_SW)) |=> state == ST_MEMWB);

  // R9: other non-halt operations return to fetch at once
  p_alu_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && d.op != OP_LW && d.op != OP_SW && d.op != OP_HALT)
      |=> state == ST_FETCH);

  // R6: an unequal compare falls through
  p_beq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && d.op == OP_BEQ && !alu_eq) |=> pc == $past(pc_inc));

  // R7: jump goes to the pre-link value of register A
  p_jalr_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && d.op == OP_JALR) |=> pc == $past(ra_data[AW-1:0]));
endmodule

// File: tb/mc8_core_tb.sv
`timescale 1ns/1ps
module mc8_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        halted;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [7:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [2:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_reg_data;
  logic [7:0]  dbg_mem_addr = '0;
  logic [31:0] dbg_mem_data;
  logic [31:0] instr_count;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mc8_core u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .halted(halted),
    .load_valid(load_valid), .load_ready(load_ready),
    .load_addr(load_addr), .load_data(load_data),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data),
    .instr_count(instr_count)
  );

  function automatic logic [31:0] enc_r(input logic [2:0] op, a, b, dst);
    return {7'b0, op, a, b, 13'b0, dst};
  endfunction

  function automatic logic [31:0] enc_i(input logic [2:0] op, a, b, input logic [15:0] off);
    return {7'b0, op, a, b, off};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    load_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic preload(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    load_valid = 1'b1;
    load_addr  = a;
    load_data  = v;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] i, output logic [31:0] v);
    dbg_reg_sel = i;
    #0.1;
    v = dbg_reg_data;
  endtask

  task automatic rd_mem(input logic [7:0] a, output logic [31:0] v);
    dbg_mem_addr = a;
    #0.1;
    v = dbg_mem_data;
  endtask

  task automatic run(output int cycles);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!halted && cycles < 2000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 halted", {31'b0, halted}, 32'd0);
    chk("R1 load_ready", {31'b0, load_ready}, 32'd1);
    chk("R1 count", instr_count, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd_reg(3'(i), v);
      chk("R1 reg zero", v, 32'd0);
    end
  endtask

  task automatic t_arith();
    logic [31:0] v;
    int cyc;
    do_reset();
    preload(0, enc_i(3'd2, 3'd0, 3'd1, 16'd20));
    preload(1, enc_i(3'd2, 3'd0, 3'd2, 16'd21));
    preload(2, enc_r(3'd0, 3'd1, 3'd2, 3'd3) | 32'hFE00_FFF8);
    preload(3, enc_r(3'd1, 3'd1, 3'd2, 3'd4));
    preload(4, enc_r(3'd0, 3'd1, 3'd1, 3'd0));
    preload(5, enc_i(3'd3, 3'd1, 3'd3, 16'd25));
    preload(6, enc_i(3'd2, 3'd2, 3'd5, 16'd24));
    preload(7, enc_i(3'd2, 3'd7, 3'd6, 16'hFFFF));
    preload(8, enc_r(3'd7, 3'd0, 3'd0, 3'd0));
    preload(9, enc_r(3'd6, 3'd0, 3'd0, 3'd0));
    preload(20, 32'd5);
    preload(21, 32'hFFFF_FFFF);
    preload(23, 32'h0000_1234);
    preload(255, 32'h0000_ABCD);
    rd_mem(20, v);
    chk("R2 preload readback", v, 32'd5);
    run(cyc);
    chk("R9 arith cycles", 32'(cyc), 32'd26);
    chk("R10 arith count", instr_count, 32'd10);
    chk("R8 halted", {31'b0, halted}, 32'd1);
    rd_reg(1, v); chk("R5 load r1", v, 32'd5);
    rd_reg(3, v); chk("R3 R4 add ignores junk bits", v, 32'd4);
    rd_reg(4, v); chk("R4 nand", v, 32'hFFFF_FFFA);
    rd_reg(0, v); chk("R4 reg0 writable", v, 32'd10);
    rd_mem(30, v); chk("R5 store", v, 32'd4);
    rd_reg(5, v); chk("R5 negative base", v, 32'h0000_1234);
    rd_reg(6, v); chk("R5 address wrap", v, 32'h0000_ABCD);
    rd_reg(7, v); chk("R8 noop untouched r7", v, 32'd0);
  endtask

  task automatic t_flow();
    logic [31:0] v;
    int cyc;
    do_reset();
    preload(0,  enc_i(3'd2, 3'd0, 3'd1, 16'd30));
    preload(1,  enc_i(3'd2, 3'd0, 3'd2, 16'd31));
    preload(2,  enc_i(3'd2, 3'd0, 3'd3, 16'd32));
    preload(3,  enc_i(3'd4, 3'd1, 3'd2, 16'd2));
    preload(4,  enc_r(3'd0, 3'd1, 3'd1, 3'd7));
    preload(5,  enc_r(3'd6, 3'd0, 3'd0, 3'd0));
    preload(6,  enc_i(3'd4, 3'd1, 3'd0, 16'd1));
    preload(7,  enc_r(3'd5, 3'd3, 3'd4, 3'd0));
    preload(8,  enc_r(3'd6, 3'd0, 3'd0, 3'd0));
    preload(9,  enc_r(3'd6, 3'd0, 3'd0, 3'd0));
    preload(10, enc_i(3'd2, 3'd0, 3'd5, 16'd33));
    preload(11, enc_r(3'd5, 3'd5, 3'd5, 3'd0));
    preload(12, enc_r(3'd6, 3'd0, 3'd0, 3'd0));
    preload(13, enc_r(3'd6, 3'd0, 3'd0, 3'd0));
    preload(14, enc_i(3'd4, 3'd0, 3'd0, 16'hFFFE));
    preload(30, 32'd7);
    preload(31, 32'd7);
    preload(32, 32'd10);
    preload(33, 32'd14);
    run(cyc);
    chk("R9 flow cycles", 32'(cyc), 32'd25);
    chk("R6 R7 flow count", instr_count, 32'd10);
    rd_reg(7, v); chk("R6 taken branch skipped add", v, 32'd0);
    rd_reg(4, v); chk("R7 link value", v, 32'd8);
    rd_reg(5, v); chk("R7 same register link", v, 32'd12);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    int cyc;
    do_reset();
    preload(0, enc_r(3'd7, 3'd0, 3'd0, 3'd0));
    preload(1, enc_r(3'd7, 3'd0, 3'd0, 3'd0));
    preload(2, enc_r(3'd6, 3'd0, 3'd0, 3'd0));
    preload(40, 32'h0000_0055);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    load_valid = 1'b1;
    load_addr  = 40;
    load_data  = 32'hDEAD_BEEF;
    chk("R2 ready low while running", {31'b0, load_ready}, 32'd0);
    cyc = 1;
    while (!halted && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R9 noop cycles", 32'(cyc), 32'd7);
    chk("R10 halt counted", instr_count, 32'd3);
    chk("R11 ready low when halted", {31'b0, load_ready}, 32'd0);
    load_valid = 1'b0;
    rd_mem(40, v);
    chk("R11 preload ignored after start", v, 32'h0000_0055);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 start ignored when halted", instr_count, 32'd3);
    chk("R8 still halted", {31'b0, halted}, 32'd1);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    t_reset();
    t_arith();
    t_flow();
    t_lock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule